// File: doc/BRIEF.md
# Invertible Scan Chain Fault Locator

This block is a mux-D scan chain whose cells can also complement their stored value in place, together with a small controller that uses that ability to find a stuck cell in the chain. When idle, every cell captures its bit of the functional data word on each clock. On a start request the controller runs a fixed three-step diagnosis. It shifts a constant stream into the chain, complements every cell in a single clock, and then unloads the chain while recording the scan output. It reports whether the recorded stream has the shape a single stuck cell produces, and if it does, where that cell sits.

A mode input chooses which fault polarity is searched for. Mode 0 shifts in ones and locates a cell stuck at 0. Mode 1 shifts in zeros and locates a cell stuck at 1. An injection port lets a testbench force the output of one chosen cell to a constant, so that faults can be created without altering the chain.

Top module: `scan_fault_locator`

## Requirements
- R1: While reset is asserted and on the first cycle after it, busy, done, fault_found and fault_index are all 0. With no injection, scan_out is also 0.
- R2: When idle, every cell loads its func_data bit on each rising edge. Cell 0 is next to the scan input and cell CHAIN_LEN-1 drives scan_out, so scan_out equals the func_data[CHAIN_LEN-1] value that was present at the previous edge.
- R3: A start seen while idle makes busy high from the next cycle. A start seen while busy has no effect on the running diagnosis or on its timing.
- R4: A diagnosis has four steps in order. The chain shifts for CHAIN_LEN cycles, then inverts for exactly one cycle with scan-enable low, then unloads for CHAIN_LEN+1 samples, then spends one report cycle. done is high for exactly one cycle. It rises on the (2*CHAIN_LEN+4)th rising edge, counting the edge that accepts start as the first. busy is low while done is high.
- R5: In mode 0, with cell k (0..CHAIN_LEN-1) forced to 0, the run ends with fault_found=1 and fault_index=k.
- R6: In mode 1, with cell k forced to 1, the run ends with fault_found=1 and fault_index=k.
- R7: With no forced cell, the run ends with fault_found=0 and fault_index=0 in either mode.
- R8: A fault whose polarity is opposite to the mode gives fault_found=0 and fault_index=0. That is, a cell stuck at 1 in mode 0, or a cell stuck at 0 in mode 1.
- R9: mode is sampled only when start is accepted. fault_found and fault_index change only in the cycle where done is high, and otherwise hold their last report.
- R10: When inj_en is 1, the output of the cell selected by inj_sel equals inj_val whatever the cell stores. With inj_sel=CHAIN_LEN-1, this shows directly on scan_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request one diagnosis run |
| mode | input | 1 | 0 locates a stuck-at-0 cell, 1 locates a stuck-at-1 cell |
| func_data | input | CHAIN_LEN | Functional capture data, bit i feeds cell i |
| inj_en | input | 1 | Enable fault injection (test use) |
| inj_sel | input | IDX_W | Index of the cell to force |
| inj_val | input | 1 | Constant forced on the selected cell output |
| scan_out | output | 1 | Output of the last cell in the chain |
| busy | output | 1 | A diagnosis run is in progress |
| done | output | 1 | One-cycle pulse when a report is ready |
| fault_found | output | 1 | Last run saw a stuck-cell signature |
| fault_index | output | IDX_W | Index of the stuck cell, 0 when none |

## Verification
The bench builds the block with the default chain length of 16. This keeps every run short, so it can sweep a forced cell through all sixteen positions in both polarities, including the two end cells. Cell 0 gives the longest leading run in the unloaded stream. The last cell produces a stream that differs from a fault-free stream only in the extra sample taken after the chain is emptied. The same length also makes the fixed latency of 36 edges, and the mid-run start and mode changes, cheap to check against hand-computed cycle counts.

// File: rtl/slf_pkg.sv
// Shared types for the invertible scan chain fault locator.
package slf_pkg;

    // Controller sequence: idle, shift-in, in-place invert, unload, report.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOAD   = 3'd1,
        ST_FLIP   = 3'd2,
        ST_UNLOAD = 3'd3,
        ST_REPORT = 3'd4
    } slf_state_e;

endpackage

// File: rtl/slf_cell.sv
// One scan cell. It chooses between functional data and the previous
// cell's output under scan_en, and complements its own stored value
// when flip is high (flip wins over scan_en).
// Assumes: force_en is only used by a test environment. It replaces the
// cell's visible output, never the stored value.
module slf_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic scan_en,
    input  logic flip,
    input  logic si,
    input  logic fd,
    input  logic force_en,
    input  logic force_val,
    output logic so
);

    logic q;

    // Storage: invert in place, shift, or capture functional data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (flip) begin
            q <= ~q;
        end else if (scan_en) begin
            q <= si;
        end else begin
            q <= fd;
        end
    end

    // Visible output, replaced by the injected constant when forced.
    always_comb begin
        so = force_en ? force_val : q;
    end

endmodule

// File: rtl/slf_chain.sv
// Chain of CHAIN_LEN invertible scan cells. Cell 0 takes scan_in and
// cell CHAIN_LEN-1 drives scan_out.
// Assumes: at most one cell is forced, the one selected by inj_sel.
module slf_chain #(
    parameter int CHAIN_LEN = 16,
    parameter int IDX_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scan_en,
    input  logic                 flip,
    input  logic                 scan_in,
    input  logic [CHAIN_LEN-1:0] func_data,
    input  logic                 inj_en,
    input  logic [IDX_W-1:0]     inj_sel,
    input  logic                 inj_val,
    output logic                 scan_out
);

    logic [CHAIN_LEN:0] link;

    // Head of the chain.
    always_comb begin
        link[0] = scan_in;
    end

    for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
        logic hit;

        // Decode whether this cell is the injection target.
        always_comb begin
            hit = inj_en && (inj_sel == IDX_W'(i));
        end

        slf_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .scan_en   (scan_en),
            .flip      (flip),
            .si        (link[i]),
            .fd        (func_data[i]),
            .force_en  (hit),
            .force_val (inj_val),
            .so        (link[i+1])
        );
    end

    // Tail of the chain.
    always_comb begin
        scan_out = link[CHAIN_LEN];
    end

endmodule

// File: rtl/slf_ctrl.sv
// Diagnosis sequencer. It shifts CHAIN_LEN fill bits in, inverts for one
// cycle, then takes CHAIN_LEN+1 unload samples and spends one report cycle.
// Assumes: start is ignored outside the idle state. mode is latched when
// start is accepted.
module slf_ctrl #(
    parameter int CHAIN_LEN = 16,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode,
    output logic             busy,
    output logic             scan_en,
    output logic             flip,
    output logic             fill,
    output logic             sample_en,
    output logic [CNT_W-1:0] sample_idx,
    output logic             report,
    output logic             mode_q
);

    import slf_pkg::*;

    localparam logic [CNT_W-1:0] LOAD_LAST   = CNT_W'(CHAIN_LEN - 1);
    localparam logic [CNT_W-1:0] UNLOAD_LAST = CNT_W'(CHAIN_LEN);

    slf_state_e       state;
    logic [CNT_W-1:0] cnt;

    // Sequence state, step counter and latched polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            mode_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state  <= ST_LOAD;
                        cnt    <= '0;
                        mode_q <= mode;
                    end
                end
                ST_LOAD: begin
                    if (cnt == LOAD_LAST) begin
                        state <= ST_FLIP;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_FLIP: begin
                    state <= ST_UNLOAD;
                    cnt   <= '0;
                end
                ST_UNLOAD: begin
                    if (cnt == UNLOAD_LAST) begin
                        state <= ST_REPORT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_REPORT: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Chain controls and sampling strobes decoded from the state.
    always_comb begin
        busy       = (state != ST_IDLE);
        scan_en    = (state == ST_LOAD) || (state == ST_UNLOAD);
        flip       = (state == ST_FLIP);
        fill       = ~mode_q;
        sample_en  = (state == ST_UNLOAD);
        sample_idx = cnt;
        report     = (state == ST_REPORT);
    end

endmodule

// File: rtl/slf_decode.sv
// Stream analyser. Sample 0 is the first bit unloaded. After folding by
// polarity, a single stuck cell at index k shows as (CHAIN_LEN-1-k) ones
// followed only by zeros. Any other shape is reported as no fault.
// Assumes: the stream holds CHAIN_LEN+1 samples, the last one taken after
// the chain has been emptied.
module slf_decode #(
    parameter int CHAIN_LEN = 16,
    parameter int IDX_W     = 4
) (
    input  logic [CHAIN_LEN:0] stream,
    input  logic               mode,
    output logic               found,
    output logic [IDX_W-1:0]   index
);

    logic [CHAIN_LEN:0] norm;
    logic               seen_zero;
    logic               bad;
    int                 ones;

    // Fold the stream so that both polarities share one pattern.
    always_comb begin
        norm = mode ? ~stream : stream;
    end

    // Count the leading run and reject any one that follows a zero.
    always_comb begin
        seen_zero = 1'b0;
        bad       = 1'b0;
        ones      = 0;
        for (int j = 0; j <= CHAIN_LEN; j++) begin
            if (!norm[j]) begin
                seen_zero = 1'b1;
            end else if (seen_zero) begin
                bad = 1'b1;
            end else begin
                ones = ones + 1;
            end
        end
        found = !bad && (ones < CHAIN_LEN);
        index = found ? IDX_W'(CHAIN_LEN - 1 - ones) : '0;
    end

endmodule

// File: rtl/scan_fault_locator.sv
// Top level: invertible scan chain plus the shift-invert-unload locator.
// It records the unloaded stream, decodes it and holds the report until
// the next run completes.
// Assumes: CHAIN_LEN >= 2. inj_* are driven only by a test environment.
module scan_fault_locator #(
    parameter int  CHAIN_LEN = 16,
    localparam int IDX_W     = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1,
    localparam int CNT_W     = $clog2(CHAIN_LEN + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 mode,
    input  logic [CHAIN_LEN-1:0] func_data,
    input  logic                 inj_en,
    input  logic [IDX_W-1:0]     inj_sel,
    input  logic                 inj_val,
    output logic                 scan_out,
    output logic                 busy,
    output logic                 done,
    output logic                 fault_found,
    output logic [IDX_W-1:0]     fault_index
);

    logic               scan_en_w;
    logic               flip_w;
    logic               fill_w;
    logic               sample_en_w;
    logic [CNT_W-1:0]   sample_idx_w;
    logic               report_w;
    logic               mode_q_w;
    logic [CHAIN_LEN:0] capture_q;
    logic               dec_found;
    logic [IDX_W-1:0]   dec_index;
    logic               found_q;
    logic [IDX_W-1:0]   index_q;
    logic               done_q;

    slf_ctrl #(
        .CHAIN_LEN (CHAIN_LEN),
        .CNT_W     (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode       (mode),
        .busy       (busy),
        .scan_en    (scan_en_w),
        .flip       (flip_w),
        .fill       (fill_w),
        .sample_en  (sample_en_w),
        .sample_idx (sample_idx_w),
        .report     (report_w),
        .mode_q     (mode_q_w)
    );

    slf_chain #(
        .CHAIN_LEN (CHAIN_LEN),
        .IDX_W     (IDX_W)
    ) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_en   (scan_en_w),
        .flip      (flip_w),
        .scan_in   (fill_w),
        .func_data (func_data),
        .inj_en    (inj_en),
        .inj_sel   (inj_sel),
        .inj_val   (inj_val),
        .scan_out  (scan_out)
    );

    // Record each unload sample at its position in the stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            capture_q <= '0;
        end else if (sample_en_w) begin
            capture_q[sample_idx_w] <= scan_out;
        end
    end

    slf_decode #(
        .CHAIN_LEN (CHAIN_LEN),
        .IDX_W     (IDX_W)
    ) u_decode (
        .stream (capture_q),
        .mode   (mode_q_w),
        .found  (dec_found),
        .index  (dec_index)
    );

    // Register the report and raise done for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            found_q <= 1'b0;
            index_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= report_w;
            if (report_w) begin
                found_q <= dec_found;
                index_q <= dec_index;
            end
        end
    end

    // Drive the report outputs.
    always_comb begin
        done        = done_q;
        fault_found = found_q;
        fault_index = index_q;
    end

endmodule

// File: rtl/slf_checker.sv
// Protocol checker for scan_fault_locator, attached with bind below.
module slf_checker #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             scan_en,
    input logic             flip,
    input logic             fault_found,
    input logic [IDX_W-1:0] fault_index
);

    // R1: quiet outputs right after reset.
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!busy && !done));

    // R3: an accepted start makes the block busy.
    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R4: the invert step runs with scan-enable low.
    p_flip_no_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flip |-> !scan_en);

    // R4: the invert step lasts exactly one cycle.
    p_flip_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flip |=> !flip);

    // R4: done is a single-cycle pulse.
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: done only appears when the run has finished.
    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4: done follows a busy period.
    p_done_after_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R9: the report changes only alongside done.
    p_report_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(fault_found) || !$stable(fault_index)) |-> done);

endmodule

bind scan_fault_locator slf_checker #(
    .IDX_W (IDX_W)
) u_slf_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .scan_en     (scan_en_w),
    .flip        (flip_w),
    .fault_found (fault_found),
    .fault_index (fault_index)
);

// File: tb/scan_fault_locator_tb.sv
module scan_fault_locator_tb;

    localparam int N   = 16;
    localparam int IW  = 4;
    localparam int LAT = 2 * N + 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mode = 1'b0;
    logic [N-1:0]  func_data = '0;
    logic          inj_en = 1'b0;
    logic [IW-1:0] inj_sel = '0;
    logic          inj_val = 1'b0;
    logic          scan_out;
    logic          busy;
    logic          done;
    logic          fault_found;
    logic [IW-1:0] fault_index;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    scan_fault_locator #(.CHAIN_LEN(N)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .mode        (mode),
        .func_data   (func_data),
        .inj_en      (inj_en),
        .inj_sel     (inj_sel),
        .inj_val     (inj_val),
        .scan_out    (scan_out),
        .busy        (busy),
        .done        (done),
        .fault_found (fault_found),
        .fault_index (fault_index)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Start one run from a negedge and wait for done; returns edge count.
    task automatic run_diag(input logic m, input logic ie, input int sel,
                            input logic val, output int lat);
        mode    = m;
        inj_en  = ie;
        inj_sel = IW'(sel);
        inj_val = val;
        start   = 1'b1;
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < 200) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 busy in reset", int'(busy), 0);
        check("R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 found after reset", int'(fault_found), 0);
        check("R1 index after reset", int'(fault_index), 0);
        check("R1 scan_out after reset", int'(scan_out), 0);
    endtask

    task automatic t_capture();
        func_data = 16'h8000;
        @(posedge clk);
        @(negedge clk);
        check("R2 capture one", int'(scan_out), 1);
        func_data = 16'h7FFF;
        @(posedge clk);
        @(negedge clk);
        check("R2 capture zero", int'(scan_out), 0);
        inj_en  = 1'b1;
        inj_sel = IW'(N - 1);
        inj_val = 1'b1;
        #1;
        check("R10 forced high", int'(scan_out), 1);
        func_data = 16'h8000;
        inj_val   = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R10 forced low", int'(scan_out), 0);
        inj_en    = 1'b0;
        func_data = '0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_timing();
        int lat;
        mode    = 1'b0;
        inj_en  = 1'b0;
        start   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R3 busy after start", int'(busy), 1);
        lat = 1;
        while (!done && lat < 200) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        check("R4 latency", lat, LAT);
        check("R4 busy low at done", int'(busy), 0);
        @(posedge clk);
        @(negedge clk);
        check("R4 done single cycle", int'(done), 0);
    endtask

    task automatic t_sweep(input logic m);
        int lat;
        for (int k = 0; k < N; k++) begin
            run_diag(m, 1'b1, k, m, lat);
            if (m == 1'b0) begin
                check("R5 sa0 found", int'(fault_found), 1);
                check("R5 sa0 index", int'(fault_index), k);
            end else begin
                check("R6 sa1 found", int'(fault_found), 1);
                check("R6 sa1 index", int'(fault_index), k);
            end
        end
        inj_en = 1'b0;
    endtask

    task automatic t_clean();
        int lat;
        for (int m = 0; m < 2; m++) begin
            run_diag(m[0], 1'b0, 0, 1'b0, lat);
            check("R7 clean found", int'(fault_found), 0);
            check("R7 clean index", int'(fault_index), 0);
        end
    endtask

    task automatic t_wrong_pol();
        int lat;
        int pos [3] = '{0, 7, N - 1};
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 3; p++) begin
                run_diag(m[0], 1'b1, pos[p], ~m[0], lat);
                check("R8 wrong polarity found", int'(fault_found), 0);
                check("R8 wrong polarity index", int'(fault_index), 0);
            end
        end
        inj_en = 1'b0;
    endtask

    task automatic t_latch_hold();
        int lat;
        // Mode flipped right after start must not matter.
        mode    = 1'b0;
        inj_en  = 1'b1;
        inj_sel = IW'(5);
        inj_val = 1'b0;
        start   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        mode  = 1'b1;
        lat = 1;
        while (!done && lat < 200) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        check("R9 mode latched found", int'(fault_found), 1);
        check("R9 mode latched index", int'(fault_index), 5);
        // A clean run must leave the old report visible until it ends.
        inj_en = 1'b0;
        mode   = 1'b0;
        start  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(posedge clk);
        @(negedge clk);
        check("R9 report held mid run", int'(fault_found), 1);
        check("R9 index held mid run", int'(fault_index), 5);
        while (!done) @(negedge clk);
        check("R9 new report", int'(fault_found), 0);
    endtask

    task automatic t_start_ignored();
        int lat;
        mode    = 1'b0;
        inj_en  = 1'b1;
        inj_sel = IW'(3);
        inj_val = 1'b0;
        start   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        lat = 1;
        repeat (6) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        start = 1'b1;
        mode  = 1'b1;
        @(posedge clk);
        lat++;
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < 200) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        check("R3 latency with extra start", lat, LAT);
        check("R3 result with extra start", int'(fault_index), 3);
        @(posedge clk);
        @(negedge clk);
        check("R3 no restart", int'(busy), 0);
        inj_en = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_capture();
        t_timing();
        t_sweep(1'b0);
        t_sweep(1'b1);
        t_clean();
        t_wrong_pol();
        t_latch_hold();
        t_start_ignored();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule